// File: doc/BRIEF.md
# Serial PCM Receive Deserializer with Static-Clock Mode Select

This block takes one serial voice sample per receive frame and hands a 13-bit two's-complement word to the next stage. It samples the serial data line on the falling edge of a bit clock. Frames are marked by a sync pulse that may be short (high for a single falling edge) or long (high for two or more falling edges). The receive sync needs no fixed phase relation to the transmit sync. Every pin is brought into a single fast master clock through synchronizers. All decoding runs in that domain.

The receive bit clock pin also selects the mode. While it toggles, frames are 13 bits wide and are clocked by it. If it stops toggling for at least `STATIC_CYC` master cycles, the block switches to 16-bit frames clocked by the transmit bit clock, and the static level picks the layout. A low level selects a sign-padded word. A high level selects a word that ends in a 3-bit receive attenuation code. If the receive sync stops while the transmit sync keeps running, the block delivers a single zero sample so that the downstream path settles at mid-scale.

Samples leave on a valid/ready stream with no back-pressure on the serial side. `smp_valid` stays high until `smp_ready` accepts the word. A newer frame that completes before acceptance replaces the held word. The attenuation code is a plain level output.

Top module: `pcm_rx_port`

## Requirements
- R1: With the receive bit clock toggling and a short sync (high at exactly one falling edge), the 13 bits on the falling edges that follow that edge are collected MSB first and delivered as `smp_data`.
- R2: With a long sync (high at two or more consecutive falling edges), the first bit is the one sampled at the first falling edge with sync high, and 13 bits are collected MSB first.
- R3: If the receive bit clock shows no edge for `STATIC_CYC` (16) master cycles, it is treated as static: level 0 selects sign-padded mode and level 1 selects gain mode. Any edge on it returns the block to the 13-bit normal mode.
- R4: In sign-padded mode, bits are sampled on transmit bit clock falling edges, and a 16-bit frame is collected. The first three bits are discarded as sign copies, and the last 13 bits form the sample.
- R5: In gain mode, bits are sampled on transmit bit clock falling edges, and a 16-bit frame is collected. The first 13 bits form the sample. The last three bits form `atten_code`, with the 14th bit as its MSB, where code k means 3·k dB of attenuation.
- R6: `atten_code` reads 0 after reset and whenever the block is not in gain mode.
- R7: When two transmit sync rising edges occur with no receive sync rising edge between them, one sample of value 0 is delivered. Further transmit syncs deliver nothing more until a receive sync rising edge occurs again.
- R8: `smp_valid` stays high with stable `smp_data` until accepted by `smp_ready`. Each completed frame produces exactly one sample, and a frame that completes while a sample is still held replaces that sample.
- R9: After reset, `smp_valid` is 0, `smp_data` is 0 and `atten_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, much faster than the bit clocks |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bclk | input | 1 | Receive bit clock, or a static mode level |
| rx_fsync | input | 1 | Receive frame sync |
| rx_din | input | 1 | Serial receive data |
| tx_bclk | input | 1 | Transmit bit clock, used for reception in the static modes |
| tx_fsync | input | 1 | Transmit frame sync, used only for receive-idle detection |
| smp_valid | output | 1 | Sample stream valid |
| smp_ready | input | 1 | Sample stream ready |
| smp_data | output | SMP_W | Received two's-complement sample |
| atten_code | output | ATT_W | Receive attenuation code, 3 dB per step |

## Verification
The assertions assume that each bit clock half-period spans at least two master cycles after synchronization, so falling-edge pulses never fall on adjacent cycles. They also assume that, in normal mode, the receive bit clock toggles well within `STATIC_CYC` cycles. They further assume that data and sync change only near the bit clock rising edge. The stimulus meets these assumptions by holding each bit clock level for three master cycles and changing data and sync together with the rising edge. It also runs a few preamble clock cycles before each frame so that a mode change settles before the sync arrives.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  typedef enum logic [1:0] {
    RXM_NORMAL  = 2'd0,
    RXM_SIGNEXT = 2'd1,
    RXM_GAIN    = 2'd2
  } rx_mode_e;
endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pcm_rx_clkmon.sv
module pcm_rx_clkmon
  import pcm_rx_pkg::*;
#(
  parameter int STATIC_CYC = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bclk_s,
  output rx_mode_e mode
);
  localparam int CW = $clog2(STATIC_CYC + 1);

  logic          prev;
  logic [CW-1:0] quiet;
  logic          edge_seen;

  assign edge_seen = bclk_s ^ prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= 1'b0;
      quiet <= '0;
      mode  <= RXM_NORMAL;
    end else begin
      prev <= bclk_s;
      if (edge_seen)                      quiet <= '0;
      else if (quiet != CW'(STATIC_CYC))  quiet <= quiet + 1'b1;
      if (quiet == CW'(STATIC_CYC))
        mode <= bclk_s ? RXM_GAIN : RXM_SIGNEXT;
      else
        mode <= RXM_NORMAL;
    end
  end

  // R3: any edge on the receive bit clock leads back to normal mode
  p_edge_normal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> ##1 (mode == RXM_NORMAL));
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
  import pcm_rx_pkg::*;
#(
  parameter int SMP_W = 13,
  parameter int ATT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall,
  input  logic             fs,
  input  logic             din,
  input  rx_mode_e         mode,
  output logic             done,
  output logic [SMP_W-1:0] word_smp,
  output logic [ATT_W-1:0] word_att
);
  localparam int WIDE_W = SMP_W + ATT_W;
  localparam int CNT_W  = $clog2(WIDE_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_PEND, ST_BUSY} dst_e;

  dst_e              st;
  rx_mode_e          mode_q;
  logic              fs_prev;
  logic [WIDE_W-1:0] sr;
  logic [WIDE_W-1:0] sr_next;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  nbits;

  assign sr_next = {sr[WIDE_W-2:0], din};
  assign nbits   = (mode_q == RXM_NORMAL) ? CNT_W'(SMP_W) : CNT_W'(WIDE_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      mode_q  <= RXM_NORMAL;
      fs_prev <= 1'b0;
      sr      <= '0;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (mode != mode_q) begin
        mode_q <= mode;
        st     <= ST_IDLE;
        cnt    <= '0;
      end else if (fall) begin
        fs_prev <= fs;
        if (fs && !fs_prev) begin
          sr  <= sr_next;
          cnt <= CNT_W'(1);
          st  <= ST_PEND;
        end else begin
          case (st)
            ST_PEND: begin
              sr <= sr_next;
              st <= ST_BUSY;
              cnt <= fs ? CNT_W'(2) : CNT_W'(1);
            end
            ST_BUSY: begin
              sr  <= sr_next;
              cnt <= cnt + 1'b1;
              if (cnt + 1'b1 == nbits) begin
                done <= 1'b1;
                st   <= ST_IDLE;
              end
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    word_smp = sr[SMP_W-1:0];
    word_att = '0;
    if (mode_q == RXM_GAIN) begin
      word_smp = sr[WIDE_W-1:ATT_W];
      word_att = sr[ATT_W-1:0];
    end
  end

  // R8: one completion pulse per frame
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1: a frame in progress never runs past its length
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUSY) |-> (cnt < nbits));
endmodule

// File: rtl/pcm_rx_idle.sv
module pcm_rx_idle #(
  parameter int IDLE_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_fs_s,
  input  logic tx_fs_s,
  output logic zero_req
);
  localparam int CW = $clog2(IDLE_FRAMES + 1);

  logic          rx_prev, tx_prev;
  logic [CW-1:0] cnt;
  logic          rx_rise, tx_rise;

  assign rx_rise = rx_fs_s & ~rx_prev;
  assign tx_rise = tx_fs_s & ~tx_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_prev  <= 1'b0;
      tx_prev  <= 1'b0;
      cnt      <= '0;
      zero_req <= 1'b0;
    end else begin
      rx_prev  <= rx_fs_s;
      tx_prev  <= tx_fs_s;
      zero_req <= 1'b0;
      if (rx_rise) begin
        cnt <= '0;
      end else if (tx_rise && cnt != CW'(IDLE_FRAMES)) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(IDLE_FRAMES - 1)) zero_req <= 1'b1;
      end
    end
  end

  // R7: the zero flush is a single pulse
  p_zero_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> !zero_req);
endmodule

// File: rtl/pcm_rx_port.sv
module pcm_rx_port
  import pcm_rx_pkg::*;
#(
  parameter int SMP_W       = 13,
  parameter int ATT_W       = 3,
  parameter int STATIC_CYC  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_FRAMES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bclk,
  input  logic             rx_fsync,
  input  logic             rx_din,
  input  logic             tx_bclk,
  input  logic             tx_fsync,
  output logic             smp_valid,
  input  logic             smp_ready,
  output logic [SMP_W-1:0] smp_data,
  output logic [ATT_W-1:0] atten_code
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] raw_v, syn_v;
  logic rx_bclk_s, tx_bclk_s, rx_fs_s, tx_fs_s, din_s;
  rx_mode_e mode;
  logic sel_bclk, sel_prev, fall;
  logic done, zero_req;
  logic [SMP_W-1:0] word_smp;
  logic [ATT_W-1:0] word_att;

  assign raw_v = {rx_bclk, tx_bclk, rx_fsync, tx_fsync, rx_din};
  assign {rx_bclk_s, tx_bclk_s, rx_fs_s, tx_fs_s, din_s} = syn_v;

  pcm_rx_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_v), .q(syn_v));

  pcm_rx_clkmon #(.STATIC_CYC(STATIC_CYC)) u_clkmon (
    .clk(clk), .rst_n(rst_n), .bclk_s(rx_bclk_s), .mode(mode));

  assign sel_bclk = (mode == RXM_NORMAL) ? rx_bclk_s : tx_bclk_s;
  assign fall     = sel_prev & ~sel_bclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_prev <= 1'b0;
    else        sel_prev <= sel_bclk;
  end

  pcm_rx_deser #(.SMP_W(SMP_W), .ATT_W(ATT_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .fall(fall), .fs(rx_fs_s), .din(din_s),
    .mode(mode), .done(done), .word_smp(word_smp), .word_att(word_att));

  pcm_rx_idle #(.IDLE_FRAMES(IDLE_FRAMES)) u_idle (
    .clk(clk), .rst_n(rst_n), .rx_fs_s(rx_fs_s), .tx_fs_s(tx_fs_s),
    .zero_req(zero_req));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_valid  <= 1'b0;
      smp_data   <= '0;
      atten_code <= '0;
    end else begin
      if (done) begin
        smp_valid <= 1'b1;
        smp_data  <= word_smp;
      end else if (zero_req) begin
        smp_valid <= 1'b1;
        smp_data  <= '0;
      end else if (smp_valid && smp_ready) begin
        smp_valid <= 1'b0;
      end
      if (mode != RXM_GAIN) atten_code <= '0;
      else if (done)        atten_code <= word_att;
    end
  end

  // R8: a held sample stays offered until taken
  p_hold_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready |=> smp_valid);
  // R8: a held sample keeps its value unless a newer one arrives
  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready && !done && !zero_req |=> $stable(smp_data));
  // R6: outside gain mode the attenuation code is cleared
  p_atten_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != RXM_GAIN) |=> (atten_code == '0));
endmodule

// File: tb/pcm_rx_port_bench.sv
module pcm_rx_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic rx_bclk = 1'b0, tx_bclk = 1'b0, rx_fsync = 1'b0, tx_fsync = 1'b0;
  logic rx_din = 1'b0, smp_ready = 1'b1;
  logic smp_valid;
  logic [12:0] smp_data;
  logic [2:0]  atten_code;

  int checks = 0;
  int fails  = 0;
  int bmode  = 0;
  bit done_flag = 0;

  logic [12:0] exp_smp[$];
  logic [2:0]  exp_att[$];
  string       exp_tag[$];

  pcm_rx_port u_pcm_rx_port (
    .clk(clk), .rst_n(rst_n), .rx_bclk(rx_bclk), .rx_fsync(rx_fsync),
    .rx_din(rx_din), .tx_bclk(tx_bclk), .tx_fsync(tx_fsync),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .atten_code(atten_code));

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic bit_cyc(logic f, logic d);
    rx_fsync = f; rx_din = d;
    if (bmode == 0) rx_bclk = 1'b1;
    tx_bclk = 1'b1;
    tick(3);
    if (bmode == 0) rx_bclk = 1'b0;
    tx_bclk = 1'b0;
    tick(3);
  endtask

  task automatic send(int nb, logic [15:0] w, bit lng);
    repeat (3) bit_cyc(1'b0, 1'b0);
    if (!lng) begin
      bit_cyc(1'b1, 1'b0);
      for (int i = 0; i < nb; i++) bit_cyc(1'b0, w[nb-1-i]);
    end else begin
      for (int i = 0; i < nb; i++) bit_cyc(i < 3, w[nb-1-i]);
    end
    repeat (2) bit_cyc(1'b0, 1'b0);
  endtask

  task automatic expect_word(logic [12:0] s, logic [2:0] a, string tag);
    exp_smp.push_back(s); exp_att.push_back(a); exp_tag.push_back(tag);
  endtask

  task automatic normal_frame(logic [12:0] s, bit lng, string tag);
    expect_word(s, 3'd0, tag);
    send(13, {3'b000, s}, lng);
  endtask

  task automatic signext_frame(logic [12:0] s, bit lng);
    expect_word(s, 3'd0, "R4 sign-padded sample");
    send(16, {{3{s[12]}}, s}, lng);
  endtask

  task automatic gain_frame(logic [12:0] s, logic [2:0] a, bit lng);
    expect_word(s, a, "R5 gain-mode sample");
    send(16, {s, a}, lng);
  endtask

  task automatic set_mode(int m);
    bmode = m;
    if (m == 1) rx_bclk = 1'b0;
    if (m == 2) rx_bclk = 1'b1;
    tick(30);
  endtask

  // Reference comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && smp_valid && smp_ready) begin
      if (exp_smp.size() == 0) begin
        check(0, "R8 sample with no frame sent", smp_data, 0);
      end else begin
        logic [12:0] s;
        logic [2:0]  a;
        string       t;
        s = exp_smp.pop_front(); a = exp_att.pop_front(); t = exp_tag.pop_front();
        check(smp_data == s, t, smp_data, s);
        check(atten_code == a, {t, " attenuation"}, atten_code, a);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    #0;
    // R9 reset state
    check(smp_valid == 1'b0, "R9 valid after reset", smp_valid, 0);
    check(smp_data == 13'd0, "R9 data after reset", smp_data, 0);
    check(atten_code == 3'd0, "R9 atten after reset", atten_code, 0);

    // R1 short sync, normal mode
    normal_frame(13'h0AAA, 0, "R1 short sync");
    normal_frame(13'h1555, 0, "R1 short sync");
    normal_frame(13'h1FFF, 0, "R1 short sync");
    normal_frame(13'h0000, 0, "R1 short sync");
    normal_frame(13'h1001, 0, "R1 short sync");
    // R2 long sync
    normal_frame(13'h0F0F, 1, "R2 long sync");
    normal_frame(13'h1234, 1, "R2 long sync");
    check(atten_code == 3'd0, "R6 atten in normal mode", atten_code, 0);

    // R4 sign-padded mode (receive clock static low)
    set_mode(1);
    signext_frame(13'h1F00, 0);
    signext_frame(13'h00FF, 1);
    check(atten_code == 3'd0, "R6 atten in sign-padded mode", atten_code, 0);

    // R5 gain mode (receive clock static high)
    set_mode(2);
    gain_frame(13'h0ABC, 3'b101, 0);
    check(atten_code == 3'b101, "R5 atten code 101", atten_code, 5);
    gain_frame(13'h1357, 3'b010, 1);
    check(atten_code == 3'b010, "R5 atten code 010", atten_code, 2);
    gain_frame(13'h1800, 3'b111, 0);
    check(atten_code == 3'b111, "R5 atten code 111", atten_code, 7);

    // R3 an edge on the receive clock returns to normal mode
    set_mode(0);
    repeat (6) bit_cyc(1'b0, 1'b0);
    check(atten_code == 3'd0, "R3 normal mode restored, R6 atten cleared", atten_code, 0);
    normal_frame(13'h0777, 0, "R3 normal decode after static mode");

    // R7 receive sync silent while transmit sync runs
    expect_word(13'd0, 3'd0, "R7 zero flush");
    for (int k = 0; k < 3; k++) begin
      tx_fsync = 1'b1; tick(6); tx_fsync = 1'b0; tick(60);
    end
    check(exp_smp.size() == 0, "R7 single zero flush", exp_smp.size(), 0);

    // R8 hold and overwrite under back-pressure
    smp_ready = 1'b0;
    send(13, {3'b000, 13'h0456}, 0);
    check(smp_valid == 1'b1, "R8 valid held while not ready", smp_valid, 1);
    expect_word(13'h1ACE, 3'd0, "R8 newer sample replaces held one");
    send(13, {3'b000, 13'h1ACE}, 1);
    check(smp_valid == 1'b1 && smp_data == 13'h1ACE, "R8 held data replaced",
          smp_data, 13'h1ACE);
    smp_ready = 1'b1;
    tick(20);
    check(exp_smp.size() == 0, "R8 every frame delivered once", exp_smp.size(), 0);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule